// File: doc/BRIEF.md
# Table-Driven Register Power Sequencer

This block moves a device from one power state to another by walking a short list of commands held in a parameter-initialised ROM and applying each one to a byte-wide register bus. A command can rewrite selected bits of a register, wait until selected bits of a register reach a wanted pattern, or pause for a number of microseconds or milliseconds. A flow-select input picks which transition to run. Each transition starts at its own base index in the ROM and runs until an end command.

Every ROM entry carries three qualifier masks: host interface, silicon cut and fab. An entry takes effect only when each of its masks overlaps the matching one-hot configuration input. This lets one ROM serve several package and interface variants. Each register access is routed to one of two address spaces: the main register space or the interface-local register space. A waiting command has a programmable cycle budget. When the budget runs out, the run is abandoned and an error is reported.

Top module: `pwr_sequencer`

## Requirements
- R1: Out of a synchronous active-low reset, `busy`, `done`, `error` and `bus_req` are all low.
- R2: A `start` pulse while idle begins execution at the base index of the flow named by `flow_sel`. A `start` while busy is ignored, and the running flow completes unchanged.
- R3: A write entry (command code 0) performs one read and then one write to the same offset and space. The byte written is (old AND NOT mask) OR (value AND mask).
- R4: An entry is a 44-bit word laid out as follows: value [7:0], mask [15:8], command [17:16], space [18], interface mask [21:19] (bit 19 USB, bit 20 SDIO, bit 21 PCIe), fab mask [23:22], cut mask [27:24], offset [43:28]. The entry runs only if each of its three masks shares a set bit with the corresponding one-hot configuration input. Otherwise the entry is skipped in one cycle and makes no bus access.
- R5: A poll entry (command code 1) rereads its register until (read byte AND mask) equals value, and then moves on.
- R6: Suppose a poll read completes without a match once the poll has spent at least `poll_limit` cycles. The run then stops, with `error` and `done` high.
- R7: A delay entry (command code 2) takes its unit from value bit 7 (0 for microseconds, 1 for milliseconds) and its count N from value bits [6:0]. The next entry starts exactly N×CLK_MHZ cycles later (microsecond unit), or exactly N×1000×CLK_MHZ cycles later (millisecond unit), than it would with N = 0. The entry's offset and mask are ignored, and it makes no bus access.
- R8: An end entry (command code 3) finishes the run whatever its qualifier masks hold. `done` rises and `busy` falls. `done` and `error` hold their values until the next accepted `start`.
- R9: If execution moves past the last ROM index without meeting an end entry, the run stops with `error` and `done` high.
- R10: `bus_req` stays high, with `bus_addr`, `bus_space`, `bus_we` and `bus_wdata` stable, until `bus_ack`. `bus_space` equals the entry's space bit (0 main, 1 interface-local).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the selected flow (accepted only while idle) |
| flow_sel | input | $clog2(FLOWS) | Transition to run |
| cfg_intf | input | 3 | One-hot active host interface |
| cfg_cut | input | 4 | One-hot silicon cut |
| cfg_fab | input | 2 | One-hot fab |
| poll_limit | input | TO_W | Poll cycle budget |
| busy | output | 1 | A flow is running |
| done | output | 1 | Last run finished (held) |
| error | output | 1 | Last run aborted (held) |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_space | output | 1 | 0 main space, 1 interface-local space |
| bus_addr | output | 16 | Register offset |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access complete this cycle |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |

## Verification
One flow of five qualified writes is run under three interface/cut/fab combinations. Each combination selects a different subset of entries. The bus transaction count, together with bytes that must or must not change, separates correct filtering from entries that are skipped wrongly or executed wrongly. The poll flow reads a register that counts upward. It is run once with a generous budget, where the exact read count pins down the match condition, and once with a tight budget, which must abort before the following write. Delays of 0, 3 µs and 1 ms are compared by their total run length, so fixed overhead cancels out and only the unit scaling remains. Further flows check an end entry with empty masks, running off the end of the table, a start issued mid-run, and an immediate end.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    parameter int OFS_W  = 16;
    parameter int CUT_W  = 4;
    parameter int FAB_W  = 2;
    parameter int INTF_W = 3;
    parameter int DATA_W = 8;

    typedef enum logic [1:0] {
        CMD_WRITE = 2'd0,
        CMD_POLL  = 2'd1,
        CMD_DELAY = 2'd2,
        CMD_END   = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [OFS_W-1:0]  offset;
        logic [CUT_W-1:0]  cut_msk;
        logic [FAB_W-1:0]  fab_msk;
        logic [INTF_W-1:0] intf_msk;
        logic              space;
        cmd_e              cmd;
        logic [DATA_W-1:0] bmask;
        logic [DATA_W-1:0] value;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/pwrseq_rom.sv
// Command ROM with qualifier match.
// Purpose : holds DEPTH entries unpacked from a flat parameter image and
//           reports whether the addressed entry applies to the configured
//           interface, cut and fab.
// Assumes : configuration inputs are one-hot; out-of-range indices read as
//           an all-ones entry, which decodes as an end command.
module pwrseq_rom #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter logic [DEPTH*pwrseq_pkg::ENTRY_W-1:0] ROM_IMAGE = '1
) (
    input  logic [IDX_W-1:0]              idx,
    input  logic [pwrseq_pkg::INTF_W-1:0] cfg_intf,
    input  logic [pwrseq_pkg::CUT_W-1:0]  cfg_cut,
    input  logic [pwrseq_pkg::FAB_W-1:0]  cfg_fab,
    output pwrseq_pkg::entry_t            ent,
    output logic                          hit
);
    import pwrseq_pkg::*;

    entry_t table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign table_q[i] = ROM_IMAGE[i*ENTRY_W +: ENTRY_W];
    end

    // Entry lookup with range guard.
    always_comb begin
        if (32'(idx) < DEPTH) ent = table_q[idx];
        else                  ent = '1;
    end

    // Qualifier match: every mask must overlap its configuration.
    always_comb begin
        hit = (|(ent.intf_msk & cfg_intf)) &&
              (|(ent.cut_msk  & cfg_cut))  &&
              (|(ent.fab_msk  & cfg_fab));
    end
endmodule

// File: rtl/pwrseq_delay.sv
// Delay timer.
// Purpose : counts down N microseconds or milliseconds after a load pulse,
//           using a prescaler that restarts on load so the wait is cycle-exact.
// Assumes : CLK_MHZ cycles form one microsecond; US_PER_MS microseconds form
//           one millisecond; load is a single-cycle pulse.
module pwrseq_delay #(
    parameter int CLK_MHZ   = 125,
    parameter int US_PER_MS = 1000,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             unit_ms,
    input  logic [CNT_W-1:0] count,
    output logic             expired
);
    localparam int PRE_W = (CLK_MHZ   > 1) ? $clog2(CLK_MHZ)   : 1;
    localparam int SUB_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

    logic [CNT_W-1:0] rem;
    logic [PRE_W-1:0] pre;
    logic [SUB_W-1:0] sub;
    logic             ms_q;

    // Load, then prescale and count down the remaining units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            pre  <= '0;
            sub  <= '0;
            ms_q <= 1'b0;
        end else if (load) begin
            rem  <= count;
            pre  <= '0;
            sub  <= '0;
            ms_q <= unit_ms;
        end else if (rem != '0) begin
            if (pre == PRE_W'(CLK_MHZ - 1)) begin
                pre <= '0;
                if (!ms_q || sub == SUB_W'(US_PER_MS - 1)) begin
                    sub <= '0;
                    rem <= rem - 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign expired = (rem == '0);

    // R7
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem != '0) |=> (rem == $past(rem) || rem == $past(rem) - 1'b1));
endmodule

// File: rtl/pwr_sequencer.sv
// Table-driven register power sequencer (top).
// Purpose : runs one transition flow from the command ROM, entry by entry,
//           issuing masked read-modify-writes, polls and timed delays on a
//           byte-wide request/acknowledge register bus.
// Assumes : FLOWS >= 2; FLOW_BASE holds one IDX_W base index per flow;
//           the bus completes an access in the cycle bus_ack is high, and a
//           request still high in the next cycle is a new access.
module pwr_sequencer #(
    parameter int CLK_MHZ   = 125,
    parameter int US_PER_MS = 1000,
    parameter int DEPTH     = 16,
    parameter int FLOWS     = 4,
    parameter int TO_W      = 16,
    parameter logic [DEPTH*pwrseq_pkg::ENTRY_W-1:0] ROM_IMAGE = '1,
    parameter logic [FLOWS*$clog2(DEPTH)-1:0]       FLOW_BASE = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(FLOWS)-1:0]      flow_sel,
    input  logic [pwrseq_pkg::INTF_W-1:0] cfg_intf,
    input  logic [pwrseq_pkg::CUT_W-1:0]  cfg_cut,
    input  logic [pwrseq_pkg::FAB_W-1:0]  cfg_fab,
    input  logic [TO_W-1:0]               poll_limit,
    output logic                          busy,
    output logic                          done,
    output logic                          error,
    output logic                          bus_req,
    output logic                          bus_we,
    output logic                          bus_space,
    output logic [pwrseq_pkg::OFS_W-1:0]  bus_addr,
    output logic [pwrseq_pkg::DATA_W-1:0] bus_wdata,
    input  logic                          bus_ack,
    input  logic [pwrseq_pkg::DATA_W-1:0] bus_rdata
);
    import pwrseq_pkg::*;

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = DATA_W - 1;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_WRD, S_WWR, S_PRD, S_DLY
    } state_e;

    state_e           state;
    logic [IDX_W-1:0] idx;
    logic [TO_W-1:0]  ptime;
    entry_t           ent;
    logic             hit;
    logic             dly_load;
    logic             dly_expired;
    logic             at_last;
    logic             poll_match;
    logic [IDX_W-1:0] flow_base;

    pwrseq_rom #(
        .DEPTH     (DEPTH),
        .IDX_W     (IDX_W),
        .ROM_IMAGE (ROM_IMAGE)
    ) u_rom (
        .idx      (idx),
        .cfg_intf (cfg_intf),
        .cfg_cut  (cfg_cut),
        .cfg_fab  (cfg_fab),
        .ent      (ent),
        .hit      (hit)
    );

    pwrseq_delay #(
        .CLK_MHZ   (CLK_MHZ),
        .US_PER_MS (US_PER_MS),
        .CNT_W     (CNT_W)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .unit_ms (ent.value[DATA_W-1]),
        .count   (ent.value[CNT_W-1:0]),
        .expired (dly_expired)
    );

    // Decode helpers for the sequencing process.
    always_comb begin
        flow_base  = FLOW_BASE[flow_sel*IDX_W +: IDX_W];
        at_last    = (idx == IDX_W'(DEPTH - 1));
        poll_match = ((bus_rdata & ent.bmask) == ent.value);
        dly_load   = (state == S_FETCH) && (ent.cmd == CMD_DELAY) && hit;
    end

    // Main sequencing state machine and bus request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            ptime     <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_space <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        idx   <= flow_base;
                        done  <= 1'b0;
                        error <= 1'b0;
                        state <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (ent.cmd == CMD_END) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (!hit || ent.cmd == CMD_DELAY) begin
                        if (hit) begin
                            state <= S_DLY;
                        end else if (at_last) begin
                            error <= 1'b1;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        bus_req   <= 1'b1;
                        bus_we    <= 1'b0;
                        bus_space <= ent.space;
                        bus_addr  <= ent.offset;
                        ptime     <= '0;
                        state     <= (ent.cmd == CMD_POLL) ? S_PRD : S_WRD;
                    end
                end
                S_WRD: begin
                    if (bus_ack) begin
                        bus_we    <= 1'b1;
                        bus_wdata <= (bus_rdata & ~ent.bmask) | (ent.value & ent.bmask);
                        state     <= S_WWR;
                    end
                end
                S_WWR: begin
                    if (bus_ack) begin
                        bus_req <= 1'b0;
                        bus_we  <= 1'b0;
                        if (at_last) begin
                            error <= 1'b1;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_FETCH;
                        end
                    end
                end
                S_PRD: begin
                    if (ptime != '1) ptime <= ptime + 1'b1;
                    if (bus_ack) begin
                        if (poll_match) begin
                            bus_req <= 1'b0;
                            if (at_last) begin
                                error <= 1'b1;
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= S_FETCH;
                            end
                        end else if (ptime >= poll_limit) begin
                            bus_req <= 1'b0;
                            error   <= 1'b1;
                            done    <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                end
                S_DLY: begin
                    if (dly_expired) begin
                        if (at_last) begin
                            error <= 1'b1;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_FETCH;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_space) && $stable(bus_wdata)));
    // R6
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && !hit && ent.cmd != CMD_END) |=> !bus_req);
    // R7
    dly_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DLY) |-> !bus_req);
    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

// File: tb/pwr_sequencer_bench.sv
module pwr_sequencer_bench;
    import pwrseq_pkg::*;

    localparam int DEPTH = 32;
    localparam int FLOWS = 8;
    localparam int MHZ   = 125;

    function automatic entry_t mk(logic [15:0] ofs, logic [3:0] cut, logic [1:0] fab,
                                  logic [2:0] intf, logic sp, cmd_e c,
                                  logic [7:0] bm, logic [7:0] val);
        entry_t e;
        e.offset = ofs; e.cut_msk = cut; e.fab_msk = fab; e.intf_msk = intf;
        e.space = sp; e.cmd = c; e.bmask = bm; e.value = val;
        return e;
    endfunction

    function automatic logic [DEPTH*ENTRY_W-1:0] build_rom();
        logic [DEPTH*ENTRY_W-1:0] img;
        img = '1;
        img[ 0*ENTRY_W +: ENTRY_W] = mk(16'h0010, 4'hF, 2'b11, 3'b111, 1'b0, CMD_WRITE, 8'hF0, 8'hA0);
        img[ 1*ENTRY_W +: ENTRY_W] = mk(16'h0011, 4'hF, 2'b11, 3'b001, 1'b0, CMD_WRITE, 8'hFF, 8'h55);
        img[ 2*ENTRY_W +: ENTRY_W] = mk(16'h0011, 4'hF, 2'b11, 3'b010, 1'b1, CMD_WRITE, 8'hFF, 8'h66);
        img[ 3*ENTRY_W +: ENTRY_W] = mk(16'h0012, 4'b0010, 2'b11, 3'b111, 1'b0, CMD_WRITE, 8'h0F, 8'h03);
        img[ 4*ENTRY_W +: ENTRY_W] = mk(16'h0013, 4'hF, 2'b10, 3'b111, 1'b0, CMD_WRITE, 8'hFF, 8'h77);
        img[ 5*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        img[ 6*ENTRY_W +: ENTRY_W] = mk(16'h0020, 4'hF, 2'b11, 3'b111, 1'b0, CMD_POLL, 8'h81, 8'h80);
        img[ 7*ENTRY_W +: ENTRY_W] = mk(16'h0021, 4'hF, 2'b11, 3'b111, 1'b1, CMD_WRITE, 8'hFF, 8'h5A);
        img[ 8*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        img[ 9*ENTRY_W +: ENTRY_W] = mk(16'h1234, 4'hF, 2'b11, 3'b111, 1'b0, CMD_DELAY, 8'hFF, 8'h00);
        img[10*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        img[11*ENTRY_W +: ENTRY_W] = mk(16'h1234, 4'hF, 2'b11, 3'b111, 1'b0, CMD_DELAY, 8'hFF, 8'h03);
        img[12*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        img[13*ENTRY_W +: ENTRY_W] = mk(16'h0000, 4'hF, 2'b11, 3'b111, 1'b0, CMD_DELAY, 8'h00, 8'h81);
        img[14*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        img[15*ENTRY_W +: ENTRY_W] = mk(16'h0030, 4'hF, 2'b11, 3'b111, 1'b0, CMD_WRITE, 8'hFF, 8'h11);
        img[16*ENTRY_W +: ENTRY_W] = mk(16'h0031, 4'hF, 2'b11, 3'b111, 1'b0, CMD_WRITE, 8'hFF, 8'h22);
        img[17*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'h0, 2'b00, 3'b000, 1'b0, CMD_END, 8'h00, 8'h00);
        img[18*ENTRY_W +: ENTRY_W] = mk(16'hFFFF, 4'hF, 2'b11, 3'b111, 1'b0, CMD_END, 8'h00, 8'h00);
        for (int k = 0; k < 4; k++)
            img[(28+k)*ENTRY_W +: ENTRY_W] = mk(16'h0040 + 16'(k), 4'hF, 2'b11, 3'b111, 1'b0,
                                                CMD_WRITE, 8'hFF, 8'h90 + 8'(k));
        return img;
    endfunction

    localparam logic [DEPTH*ENTRY_W-1:0] IMG = build_rom();
    localparam logic [FLOWS*5-1:0] BASES =
        {5'd18, 5'd28, 5'd15, 5'd13, 5'd11, 5'd9, 5'd6, 5'd0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  flow_sel = '0;
    logic [2:0]  cfg_intf = 3'b001;
    logic [3:0]  cfg_cut = 4'b0001;
    logic [1:0]  cfg_fab = 2'b01;
    logic [15:0] poll_limit = 16'd1000;
    logic        busy, done, error;
    logic        bus_req, bus_we, bus_space;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;

    pwr_sequencer #(
        .CLK_MHZ(MHZ), .US_PER_MS(1000), .DEPTH(DEPTH), .FLOWS(FLOWS), .TO_W(16),
        .ROM_IMAGE(IMG), .FLOW_BASE(BASES)
    ) u_pwr_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .flow_sel(flow_sel),
        .cfg_intf(cfg_intf), .cfg_cut(cfg_cut), .cfg_fab(cfg_fab),
        .poll_limit(poll_limit), .busy(busy), .done(done), .error(error),
        .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    // Register bus model: one-cycle ack, counting read register at main 0x20.
    logic [7:0] mac_mem [256];
    logic [7:0] loc_mem [256];
    logic [7:0] poll_ctr;
    int         txn;
    logic       clr = 1'b0;

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) begin
                mac_mem[i] <= 8'h00;
                loc_mem[i] <= 8'h00;
            end
            mac_mem[8'h10] <= 8'h3C;
            mac_mem[8'h12] <= 8'hF0;
            poll_ctr <= 8'h00;
            txn      <= 0;
            bus_ack  <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            txn     <= txn + 1;
            if (bus_we) begin
                if (bus_space) loc_mem[bus_addr[7:0]] <= bus_wdata;
                else           mac_mem[bus_addr[7:0]] <= bus_wdata;
            end else if (!bus_space && bus_addr == 16'h0020) begin
                bus_rdata <= poll_ctr;
                poll_ctr  <= poll_ctr + 1'b1;
            end else begin
                bus_rdata <= bus_space ? loc_mem[bus_addr[7:0]] : mac_mem[bus_addr[7:0]];
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic preset();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run_flow(input logic [2:0] f, input logic [2:0] itf, input logic [3:0] ct,
                            input logic [1:0] fb, input logic [15:0] lim, output int cyc);
        @(negedge clk);
        flow_sel = f; cfg_intf = itf; cfg_cut = ct; cfg_fab = fb; poll_limit = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("watchdog run", 0, 1);
    endtask

    typedef struct packed {
        logic [2:0]  flow;
        logic [2:0]  intf;
        logic [3:0]  cut;
        logic [1:0]  fab;
        logic [15:0] lim;
        logic        sp;
        logic [7:0]  addr;
        logic [7:0]  exp_byte;
        logic [15:0] exp_txn;
        logic        exp_err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'b001, 4'b0010, 2'b10, 16'd1000, 1'b0, 8'h10, 8'hAC, 16'd8,   1'b0}, // R3 merge
        '{3'd0, 3'b001, 4'b0010, 2'b10, 16'd1000, 1'b0, 8'h13, 8'h77, 16'd8,   1'b0}, // R4 fab match
        '{3'd0, 3'b010, 4'b0001, 2'b01, 16'd1000, 1'b1, 8'h11, 8'h66, 16'd4,   1'b0}, // R4 R10 local space
        '{3'd0, 3'b010, 4'b0001, 2'b01, 16'd1000, 1'b0, 8'h11, 8'h00, 16'd4,   1'b0}, // R4 skipped untouched
        '{3'd0, 3'b100, 4'b0010, 2'b01, 16'd1000, 1'b0, 8'h12, 8'hF3, 16'd4,   1'b0}, // R3 cut match
        '{3'd1, 3'b001, 4'b0001, 2'b01, 16'd1000, 1'b1, 8'h21, 8'h5A, 16'd131, 1'b0}, // R5 poll
        '{3'd1, 3'b001, 4'b0001, 2'b01, 16'd20,   1'b1, 8'h21, 8'h00, 16'hFFFF,1'b1}, // R6 timeout
        '{3'd5, 3'b001, 4'b0001, 2'b01, 16'd1000, 1'b0, 8'h31, 8'h22, 16'd4,   1'b0}, // R8 end w/o masks
        '{3'd6, 3'b001, 4'b0001, 2'b01, 16'd1000, 1'b0, 8'h43, 8'h93, 16'd8,   1'b1}, // R9 overrun
        '{3'd7, 3'b001, 4'b0001, 2'b01, 16'd1000, 1'b0, 8'h10, 8'h3C, 16'd0,   1'b0}, // R8 immediate end
        '{3'd2, 3'b001, 4'b0001, 2'b01, 16'd1000, 1'b0, 8'h34, 8'h00, 16'd0,   1'b0}  // R7 no access
    };
    localparam string VTAG [NV] = '{"R3", "R4", "R4/R10", "R4", "R3", "R5", "R6",
                                    "R8", "R9", "R8", "R7"};

    initial begin
        int cyc, d0, d3, dm;
        logic [7:0] got;
        clr = 1'b1;
        repeat (4) @(negedge clk);
        clr = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 error", error, 0);
        chk("R1 bus_req", bus_req, 0);

        for (int v = 0; v < NV; v++) begin
            preset();
            run_flow(VECS[v].flow, VECS[v].intf, VECS[v].cut, VECS[v].fab, VECS[v].lim, cyc);
            @(negedge clk);
            got = VECS[v].sp ? loc_mem[VECS[v].addr] : mac_mem[VECS[v].addr];
            chk({VTAG[v], " done"}, done, 1);
            chk({VTAG[v], " busy"}, busy, 0);
            chk({VTAG[v], " error"}, error, VECS[v].exp_err);
            chk({VTAG[v], " byte"}, got, VECS[v].exp_byte);
            if (VECS[v].exp_txn != 16'hFFFF) chk({VTAG[v], " txn"}, txn, VECS[v].exp_txn);
        end

        // R8 done and error hold while idle
        repeat (5) @(negedge clk);
        chk("R8 done held", done, 1);

        // R7 delay scaling
        preset(); run_flow(3'd2, 3'b001, 4'b0001, 2'b01, 16'd1000, d0);
        preset(); run_flow(3'd3, 3'b001, 4'b0001, 2'b01, 16'd1000, d3);
        chk("R7 us delay", d3 - d0, 3 * MHZ);
        chk("R7 us txn", txn, 0);
        preset(); run_flow(3'd4, 3'b001, 4'b0001, 2'b01, 16'd1000, dm);
        chk("R7 ms delay", dm - d0, 1000 * MHZ);

        // R2 start while busy ignored
        preset();
        @(negedge clk);
        flow_sel = 3'd1; poll_limit = 16'd1000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R2 busy mid-run", busy, 1);
        flow_sel = 3'd7; start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk("R2 flow kept", loc_mem[8'h21], 8'h5A);
        chk("R2 txn", txn, 131);
        chk("R2 error", error, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule